// File: doc/BRIEF.md
# Scatter-capable receive DMA channel over a descriptor ring

This channel takes frames from a byte-wide valid/ready stream, where the last byte of a frame is marked, and stores them in memory buffers. The buffers are listed in a ring of 16-byte descriptors. Software places descriptors in the ring and then moves a last-posted pointer past them. The channel fetches one descriptor at a time, starting at the ring base plus its current byte offset. It writes frame bytes into the buffer that descriptor names. When a frame ends, the channel goes back to the first buffer of that frame, writes the frame length there as a 16-bit header, and raises a one-cycle completion pulse.

The first buffer of a frame receives its data starting at a programmable receive offset. That leaves room for the header at the buffer start, so the offset should be at least 2. A frame that does not fit in one buffer continues at byte 0 of the next descriptor's buffer, with no header there. If the ring runs dry partway through a frame, one control bit chooses the response. With the bit clear, the channel stalls the input until more descriptors are posted. With the bit set, the channel discards the rest of the frame.

Back-pressure is carried straight through, with no storage. A data byte is taken from the stream only in the same cycle that the memory write port accepts it. While the header write is pending, while a descriptor is being fetched, and while the channel waits for buffers, `in_ready` stays low. The descriptor request and the memory write each hold their address and data until their ready input is seen high.

Top module: `rx_ring_dma`

## Requirements
- R1: While control bit 0 (enable) is clear, status0[31:28] reads 0 (disabled), status0[12:0] (current descriptor byte offset) reads 0, status1[31:28] reads 0, and `in_ready` is low. The same values hold out of reset.
- R2: With no frame in progress and the current offset equal to `cfg_last_ptr`, the channel reports state 2 (idle) in status0[31:28], keeps `in_ready` low and fetches no descriptor.
- R3: A descriptor is requested at `cfg_ring_base` + current offset. In the returned 128-bit word, bits [31:0] are the first descriptor word (bit 28 = end of table), bits [63:32] are the second word (bits 14:0 = buffer byte count, bit 18 = parity), and bits [95:64] are the buffer address.
- R4: The first byte of a frame is written to buffer address + control bits 7:1 (receive offset). Each following byte goes to the next address. Data writes have `wr_half` = 0 and the byte in `wr_data[7:0]`.
- R5: When a byte fills a buffer up to its byte count and is not the last byte of the frame, the next byte goes to offset 0 of the next descriptor's buffer. No header is written there.
- R6: After the last byte of a frame, one write with `wr_half` = 1 puts the frame length in bytes, as a little-endian 16-bit value, at the first buffer's address. `done_pulse` is high for exactly the one cycle after that write is accepted.
- R7: Each descriptor whose buffer received bytes moves the current offset on by 16. A descriptor with its end-of-table bit set moves the offset back to 0.
- R8: With control bit 10 clear, if the descriptors run out partway through a frame, `in_ready` stays low and the state reads 2 until `cfg_last_ptr` is moved on. The frame then completes with no byte lost.
- R9: With control bit 10 set, if the descriptors run out partway through a frame, the remaining bytes are accepted and discarded. No header is written and no `done_pulse` is given. The next frame uses the next posted descriptor.
- R10: With control bit 11 clear, a descriptor whose four words XOR to a value of odd parity sets status1[31:28] to 1 and state 3 (stopped). While stopped, the channel neither accepts input nor writes. With bit 11 set, the same descriptor is used normally.
- R11: A descriptor response that arrives with `dsc_rsp_err` high sets status1[31:28] to 4 and state 3.
- R12: While `wr_ready` is low, no byte is taken from the stream. Every byte is still written once, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ctrl | input | 32 | Control word: bit 0 enable, bits 7:1 receive offset, bit 10 drop on overflow, bit 11 parity check off, bits 17:16 address extension (held only) |
| cfg_ring_base | input | 32 | Byte address of descriptor 0 |
| cfg_last_ptr | input | 13 | Byte offset one past the last posted descriptor |
| status0 | output | 32 | [31:28] state, [12:0] current descriptor byte offset |
| status1 | output | 32 | [31:28] error code |
| dsc_req_valid | output | 1 | Descriptor fetch request |
| dsc_req_ready | input | 1 | Fetch request accepted |
| dsc_req_addr | output | 32 | Descriptor address |
| dsc_rsp_valid | input | 1 | Descriptor data returned |
| dsc_rsp_err | input | 1 | Descriptor read failed |
| dsc_rsp_data | input | 128 | Descriptor contents |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte taken |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Last byte of frame |
| wr_valid | output | 1 | Memory write valid |
| wr_ready | input | 1 | Memory write accepted |
| wr_addr | output | 32 | Memory byte address |
| wr_data | output | 16 | Byte in [7:0], or 16-bit length header |
| wr_half | output | 1 | 1 = two-byte little-endian write |
| done_pulse | output | 1 | Frame stored |

## Verification
Some rules are checked by assertions on every cycle. The completion pulse must follow an accepted header write. The pointer never advances while the ring is empty, and the end-of-table bit wraps the offset to zero. A stopped channel stays silent on every port and keeps its error code. Other behaviour shows only in the bench scenarios, where a behavioural model predicts every write: the exact landing address of each byte under the receive offset, the split of a frame across buffers including a wrap of the ring, the stall and its release, a dropped frame under the overflow option, and parity or read faults that reach the status words.

// File: rtl/rx_ring_dma_pkg.sv
package rx_ring_dma_pkg;

  // control word bit positions
  localparam int CTL_EN     = 0;
  localparam int CTL_OFF_LO = 1;
  localparam int CTL_OC     = 10;
  localparam int CTL_NOPAR  = 11;

  // descriptor field positions in the 128-bit fetch word
  localparam int DSC_W      = 128;
  localparam int DSC_EOT    = 28;
  localparam int DSC_BC_LO  = 32;
  localparam int DSC_ADR_LO = 64;

  typedef enum logic [3:0] {
    CH_DISABLED = 4'd0,
    CH_ACTIVE   = 4'd1,
    CH_IDLE     = 4'd2,
    CH_STOPPED  = 4'd3,
    CH_SUSPEND  = 4'd4
  } chan_state_e;

  typedef enum logic [3:0] {
    ER_NONE     = 4'd0,
    ER_PROTO    = 4'd1,
    ER_FIFO_OVF = 4'd2,
    ER_XFER     = 4'd3,
    ER_DSC_READ = 4'd4,
    ER_CORE     = 4'd5
  } chan_err_e;

  typedef enum logic [2:0] {
    PH_WAIT, PH_REQ, PH_RSP, PH_DATA, PH_HDR, PH_DROP, PH_HALT
  } phase_e;

endpackage

// File: rtl/rx_ring_ptr.sv
module rx_ring_ptr #(
  parameter int OFF_W  = 13,
  parameter int DESC_B = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             advance,
  input  logic             adv_eot,
  input  logic [OFF_W-1:0] last_ptr,
  output logic [OFF_W-1:0] cur_off,
  output logic             empty
);
  localparam logic [OFF_W-1:0] STEP = OFF_W'(DESC_B);

  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) off_q <= '0;
    else if (advance) off_q <= adv_eot ? '0 : off_q + STEP;
  end

  assign cur_off = off_q;
  assign empty   = (off_q == last_ptr);

  // R2
  adv_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> !empty);

  // R7
  wrap_to_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && adv_eot && en) |=> (cur_off == '0));
endmodule

// File: rtl/rx_desc_decode.sv
module rx_desc_decode import rx_ring_dma_pkg::*; #(
  parameter int ADDR_W  = 32,
  parameter int BC_W    = 15,
  parameter int RXOFF_W = 7
) (
  input  logic [DSC_W-1:0]   desc,
  input  logic               first,
  input  logic [RXOFF_W-1:0] rx_off,
  input  logic               par_en,
  output logic [ADDR_W-1:0]  buf_addr,
  output logic [BC_W-1:0]    buf_bc,
  output logic               eot,
  output logic               bad
);
  logic par_odd;

  always_comb begin
    buf_addr = desc[DSC_ADR_LO +: ADDR_W];
    buf_bc   = desc[DSC_BC_LO +: BC_W];
    eot      = desc[DSC_EOT];
    par_odd  = ^desc;
    bad      = (par_en && par_odd) || (buf_bc == '0) ||
               (first && (BC_W'(rx_off) >= buf_bc));
  end
endmodule

// File: rtl/rx_wr_select.sv
module rx_wr_select #(
  parameter int ADDR_W = 32,
  parameter int BC_W   = 15,
  parameter int LEN_W  = 16
) (
  input  logic              hdr_sel,
  input  logic [ADDR_W-1:0] buf_addr,
  input  logic [BC_W-1:0]   pos,
  input  logic [7:0]        byte_in,
  input  logic [ADDR_W-1:0] hdr_addr,
  input  logic [LEN_W-1:0]  flen,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LEN_W-1:0]  wr_data,
  output logic              wr_half
);
  always_comb begin
    if (hdr_sel) begin
      wr_addr = hdr_addr;
      wr_data = flen;
      wr_half = 1'b1;
    end else begin
      wr_addr = buf_addr + ADDR_W'(pos);
      wr_data = LEN_W'(byte_in);
      wr_half = 1'b0;
    end
  end
endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma import rx_ring_dma_pkg::*; #(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 13,
  parameter int BC_W    = 15,
  parameter int LEN_W   = 16,
  parameter int RXOFF_W = 7,
  parameter int DESC_B  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_ctrl,
  input  logic [ADDR_W-1:0] cfg_ring_base,
  input  logic [OFF_W-1:0]  cfg_last_ptr,
  output logic [31:0]       status0,
  output logic [31:0]       status1,
  output logic              dsc_req_valid,
  input  logic              dsc_req_ready,
  output logic [ADDR_W-1:0] dsc_req_addr,
  input  logic              dsc_rsp_valid,
  input  logic              dsc_rsp_err,
  input  logic [DSC_W-1:0]  dsc_rsp_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LEN_W-1:0]  wr_data,
  output logic              wr_half,
  output logic              done_pulse
);
  localparam int PAD_W = ADDR_W - OFF_W;

  logic en, oc, par_en;
  logic [RXOFF_W-1:0] rx_off;
  logic unused_cfg;

  assign en     = cfg_ctrl[CTL_EN];
  assign oc     = cfg_ctrl[CTL_OC];
  assign par_en = !cfg_ctrl[CTL_NOPAR];
  assign rx_off = cfg_ctrl[CTL_OFF_LO +: RXOFF_W];
  assign unused_cfg = ^{cfg_ctrl[31:12], cfg_ctrl[9:8]};

  phase_e            ph;
  logic              first_q, eot_q, done_q;
  logic [ADDR_W-1:0] buf_addr_q, hdr_addr_q;
  logic [BC_W-1:0]   buf_bc_q, pos_q;
  logic [LEN_W-1:0]  flen_q;
  chan_err_e         err_q;
  chan_state_e       st;

  logic [ADDR_W-1:0] d_addr;
  logic [BC_W-1:0]   d_bc;
  logic              d_eot, d_bad;
  logic [OFF_W-1:0]  cur_off;
  logic              empty, advance, in_hs, buf_full;

  rx_desc_decode #(.ADDR_W(ADDR_W), .BC_W(BC_W), .RXOFF_W(RXOFF_W)) u_dec (
    .desc(dsc_rsp_data), .first(first_q), .rx_off(rx_off), .par_en(par_en),
    .buf_addr(d_addr), .buf_bc(d_bc), .eot(d_eot), .bad(d_bad));

  rx_ring_ptr #(.OFF_W(OFF_W), .DESC_B(DESC_B)) u_ptr (
    .clk(clk), .rst_n(rst_n), .en(en), .advance(advance), .adv_eot(eot_q),
    .last_ptr(cfg_last_ptr), .cur_off(cur_off), .empty(empty));

  rx_wr_select #(.ADDR_W(ADDR_W), .BC_W(BC_W), .LEN_W(LEN_W)) u_wsel (
    .hdr_sel(ph == PH_HDR), .buf_addr(buf_addr_q), .pos(pos_q),
    .byte_in(in_data), .hdr_addr(hdr_addr_q), .flen(flen_q),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_half(wr_half));

  assign in_ready = en && (((ph == PH_DATA) && wr_ready) || (ph == PH_DROP));
  assign wr_valid = en && (((ph == PH_DATA) && in_valid) || (ph == PH_HDR));
  assign in_hs    = in_valid && in_ready;
  assign buf_full = ((pos_q + 1'b1) == buf_bc_q);
  assign advance  = en && (ph == PH_DATA) && in_hs && (in_last || buf_full);

  assign dsc_req_valid = en && (ph == PH_REQ);
  assign dsc_req_addr  = cfg_ring_base + {{PAD_W{1'b0}}, cur_off};
  assign done_pulse    = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= PH_WAIT; first_q <= 1'b1; eot_q <= 1'b0; done_q <= 1'b0;
      buf_addr_q <= '0; hdr_addr_q <= '0; buf_bc_q <= '0; pos_q <= '0;
      flen_q <= '0; err_q <= ER_NONE;
    end else if (!en) begin
      ph <= PH_WAIT; first_q <= 1'b1; done_q <= 1'b0; err_q <= ER_NONE;
    end else begin
      done_q <= 1'b0;
      case (ph)
        PH_WAIT: begin
          if (!empty) ph <= PH_REQ;
          else if (!first_q && oc) ph <= PH_DROP;
        end
        PH_REQ: if (dsc_req_ready) ph <= PH_RSP;
        PH_RSP: if (dsc_rsp_valid) begin
          if (dsc_rsp_err) begin
            err_q <= ER_DSC_READ; ph <= PH_HALT;
          end else if (d_bad) begin
            err_q <= ER_PROTO; ph <= PH_HALT;
          end else begin
            buf_addr_q <= d_addr;
            buf_bc_q   <= d_bc;
            eot_q      <= d_eot;
            pos_q      <= first_q ? BC_W'(rx_off) : '0;
            if (first_q) begin
              hdr_addr_q <= d_addr;
              flen_q     <= '0;
            end
            ph <= PH_DATA;
          end
        end
        PH_DATA: if (in_hs) begin
          pos_q  <= pos_q + 1'b1;
          flen_q <= flen_q + 1'b1;
          if (in_last) ph <= PH_HDR;
          else if (buf_full) begin
            first_q <= 1'b0;
            ph <= PH_WAIT;
          end
        end
        PH_HDR: if (wr_ready) begin
          done_q <= 1'b1; first_q <= 1'b1; ph <= PH_WAIT;
        end
        PH_DROP: if (in_valid && in_last) begin
          first_q <= 1'b1; ph <= PH_WAIT;
        end
        PH_HALT: ;
        default: ph <= PH_HALT;
      endcase
    end
  end

  always_comb begin
    if (!en) st = CH_DISABLED;
    else if (ph == PH_HALT) st = CH_STOPPED;
    else if ((ph == PH_WAIT) && empty) st = CH_IDLE;
    else st = CH_ACTIVE;
    status0 = '0;
    status0[31:28] = st;
    status0[OFF_W-1:0] = cur_off;
    status1 = '0;
    status1[31:28] = err_q;
  end

  // R6
  done_after_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> $past(wr_valid && wr_ready && wr_half));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status0[31:28] == 4'd3) |-> (!in_ready && !wr_valid && !dsc_req_valid));

  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status0[31:28] == 4'd3) && cfg_ctrl[0] && $stable(cfg_ctrl)) |=> $stable(status1));

  // R12
  hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_half && !wr_ready && $stable(cfg_ctrl)) |=>
      (wr_valid && wr_half && $stable(wr_addr) && $stable(wr_data)));
endmodule

// File: tb/test_rx_ring_dma.sv
`timescale 1ns/1ps
module test_rx_ring_dma;
  localparam logic [31:0] RING = 32'h0000_1000;
  localparam logic [31:0] BUFB = 32'h2000_0000;
  localparam int ND = 8;

  logic clk = 0, rst_n = 0;
  logic [31:0] cfg_ctrl = 0, cfg_ring_base = RING;
  logic [12:0] cfg_last_ptr = 0;
  logic [31:0] status0, status1;
  logic dsc_req_valid, dsc_req_ready = 1, dsc_rsp_valid, dsc_rsp_err;
  logic [31:0] dsc_req_addr;
  logic [127:0] dsc_rsp_data;
  logic in_valid = 0, in_ready, in_last = 0;
  logic [7:0] in_data = 0;
  logic wr_valid, wr_ready, wr_half, done_pulse;
  logic [31:0] wr_addr;
  logic [15:0] wr_data;

  always #5 clk = ~clk;

  rx_ring_dma i_rx_ring_dma (
    .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl), .cfg_ring_base(cfg_ring_base),
    .cfg_last_ptr(cfg_last_ptr), .status0(status0), .status1(status1),
    .dsc_req_valid(dsc_req_valid), .dsc_req_ready(dsc_req_ready),
    .dsc_req_addr(dsc_req_addr), .dsc_rsp_valid(dsc_rsp_valid),
    .dsc_rsp_err(dsc_rsp_err), .dsc_rsp_data(dsc_rsp_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_half(wr_half), .done_pulse(done_pulse));

  int total = 0, bad = 0, done_cnt = 0, exp_done = 0, m_idx = 0;
  bit ended = 0, bp_on = 0, rd_err_inject = 0;
  logic [127:0] desc_mem [ND];
  logic [31:0] d_addr [ND];
  int d_bc [ND];
  bit d_eot [ND];
  logic [48:0] exp_q [$];
  logic [31:0] cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_desc(input int i, input logic [31:0] a, input int bc, input bit eot, input bit badpar);
    logic [31:0] w0, w1, w2, w3;
    w0 = eot ? 32'h1000_0000 : 32'h0;
    w1 = 32'(bc);
    w2 = a; w3 = 32'h0;
    if (^(w0 ^ w1 ^ w2 ^ w3)) w1 = w1 | 32'h0004_0000;
    if (badpar) w1 = w1 ^ 32'h0004_0000;
    desc_mem[i] = {w3, w2, w1, w0};
    d_addr[i] = a; d_bc[i] = bc; d_eot[i] = eot;
  endtask

  // behavioural reference: predicted write list for one frame
  task automatic model_frame(input int len, input int seed, input int off, input int last_idx, input bit oc);
    int b, first, pos;
    bit dropped;
    b = m_idx; first = b; pos = off; dropped = 0;
    for (int k = 0; k < len; k++) begin
      exp_q.push_back({1'b0, d_addr[b] + 32'(pos), 8'h00, 8'(seed + k)});
      pos++;
      if (k == len - 1) b = d_eot[b] ? 0 : b + 1;
      else if (pos == d_bc[b]) begin
        b = d_eot[b] ? 0 : b + 1;
        pos = 0;
        if (oc && b == last_idx) begin dropped = 1; break; end
      end
    end
    if (!dropped) begin
      exp_q.push_back({1'b1, d_addr[first], 16'(len)});
      exp_done++;
    end
    m_idx = b;
  endtask

  task automatic send_frame(input int len, input int seed);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      in_valid = 1; in_data = 8'(seed + k); in_last = (k == len - 1);
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    in_valid = 0; in_last = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // descriptor memory and write-port readiness
  always @(posedge clk) begin
    cyc <= cyc + 1;
    wr_ready <= !bp_on || (cyc[1:0] != 2'd0);
    if (!rst_n) begin
      dsc_rsp_valid <= 0; dsc_rsp_err <= 0; dsc_rsp_data <= '0;
    end else begin
      dsc_rsp_valid <= 0;
      if (dsc_req_valid && dsc_req_ready) begin
        dsc_rsp_valid <= 1;
        dsc_rsp_err   <= rd_err_inject;
        dsc_rsp_data  <= desc_mem[(dsc_req_addr - RING) >> 4];
      end
    end
  end

  // every-clock comparison of the write stream against the model
  always begin
    @(negedge clk); #2;
    if (wr_valid && wr_ready) begin
      if (exp_q.size() == 0) chk(0, "R5 unexpected write", {15'b0, wr_half, wr_addr, wr_data}, 0);
      else begin
        logic [48:0] e;
        e = exp_q.pop_front();
        chk({wr_half, wr_addr, wr_data} == e, "R5 write stream", {15'b0, wr_half, wr_addr, wr_data}, {15'b0, e});
      end
    end
    if (done_pulse) done_cnt++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    finish_run();
  end

  initial begin
    for (int i = 0; i < ND; i++) put_desc(i, BUFB + 32'(i * 256), 64, i == ND - 1, 0);
    idle(3);
    rst_n = 1;
    idle(2);
    // R1: reset and disabled state
    chk(status0 == 0, "R1 status0", status0, 0);
    chk(status1 == 0, "R1 status1", status1, 0);
    chk(in_ready == 0, "R1 in_ready", in_ready, 0);

    // R2: enabled with nothing posted
    cfg_ctrl = 32'h9;
    idle(5);
    chk(status0[31:28] == 2, "R2 idle state", status0[31:28], 2);
    chk(in_ready == 0 && dsc_req_valid == 0, "R2 no input, no fetch", {in_ready, dsc_req_valid}, 0);

    // R3 R4 R6: single-buffer frame
    cfg_last_ptr = 64;
    model_frame(10, 1, 4, 4, 0);
    send_frame(10, 1);
    idle(6);
    chk(done_cnt == exp_done, "R6 done count", done_cnt, exp_done);
    chk(status0[12:0] == 16, "R7 offset after one", status0[12:0], 16);

    // R5: frame over three buffers
    model_frame(150, 40, 4, 4, 0);
    send_frame(150, 40);
    idle(6);
    chk(status0[12:0] == 64, "R7 offset after scatter", status0[12:0], 64);
    chk(status0[31:28] == 2, "R2 idle after ring used", status0[31:28], 2);
    chk(done_cnt == exp_done, "R5 done count", done_cnt, exp_done);

    // R12: write back-pressure
    cfg_last_ptr = 96; bp_on = 1;
    model_frame(20, 90, 4, 6, 0);
    send_frame(20, 90);
    idle(8);
    bp_on = 0;
    chk(exp_q.size() == 0, "R12 all bytes written", exp_q.size(), 0);
    chk(done_cnt == exp_done, "R12 done count", done_cnt, exp_done);

    // R8: stall until more buffers are posted
    model_frame(100, 7, 4, 7, 0);
    fork
      send_frame(100, 7);
      begin
        idle(100);
        chk(in_ready == 0, "R8 stalled ready", in_ready, 0);
        chk(status0[31:28] == 2, "R8 stalled state", status0[31:28], 2);
        cfg_last_ptr = 112;
      end
    join
    idle(6);
    chk(status0[12:0] == 112, "R8 offset after release", status0[12:0], 112);
    chk(done_cnt == exp_done, "R8 done count", done_cnt, exp_done);

    // R7: end-of-table wrap
    cfg_last_ptr = 32;
    model_frame(130, 3, 4, 2, 0);
    send_frame(130, 3);
    idle(6);
    chk(status0[12:0] == 32, "R7 wrap offset", status0[12:0], 32);
    chk(done_cnt == exp_done, "R7 done count", done_cnt, exp_done);

    // R9: drop with overflow-continue
    cfg_ctrl = 32'h409; cfg_last_ptr = 48;
    model_frame(100, 11, 4, 3, 1);
    send_frame(100, 11);
    idle(6);
    chk(done_cnt == exp_done, "R9 no done for dropped", done_cnt, exp_done);
    chk(status0[12:0] == 48, "R9 offset after drop", status0[12:0], 48);
    cfg_last_ptr = 64;
    model_frame(5, 200, 4, 4, 1);
    send_frame(5, 200);
    idle(6);
    chk(done_cnt == exp_done, "R9 next frame done", done_cnt, exp_done);
    chk(exp_q.size() == 0, "R9 writes complete", exp_q.size(), 0);

    // R1: disable clears
    cfg_ctrl = 0;
    idle(3);
    chk(status0 == 0 && status1 == 0, "R1 disable clears", status0, 0);

    // R10: parity fault
    put_desc(0, BUFB, 64, 0, 1);
    cfg_last_ptr = 16; cfg_ctrl = 32'h9;
    idle(8);
    chk(status1[31:28] == 1, "R10 parity error", status1[31:28], 1);
    chk(status0[31:28] == 3, "R10 stopped", status0[31:28], 3);
    chk(in_ready == 0, "R10 no input", in_ready, 0);
    cfg_ctrl = 0;
    idle(2);
    cfg_ctrl = 32'h809; m_idx = 0;
    model_frame(8, 77, 4, 1, 0);
    send_frame(8, 77);
    idle(6);
    chk(done_cnt == exp_done, "R10 accepted with check off", done_cnt, exp_done);
    chk(status1 == 0, "R10 no error with check off", status1, 0);

    // R11: descriptor read error
    cfg_ctrl = 0;
    put_desc(0, BUFB, 64, 0, 0);
    rd_err_inject = 1;
    idle(2);
    cfg_ctrl = 32'h9;
    idle(8);
    chk(status1[31:28] == 4, "R11 read error", status1[31:28], 4);
    chk(status0[31:28] == 3, "R11 stopped", status0[31:28], 3);
    rd_err_inject = 0;
    chk(exp_q.size() == 0, "R4 no pending writes", exp_q.size(), 0);
    finish_run();
  end
endmodule